// File: doc/BRIEF.md
# Mailbox Response Receive Sequencer

This block runs on the host side of a byte-wide status/data mailbox and collects one response packet into a local byte buffer. A single `start` pulse launches the sequence. The block first polls the status port until the frame flag shows that a response is ready. It then checks the leading mode byte. After that it pulls payload bytes while the output-full flag is set, and the payload phase ends when the frame flag reappears or when the buffer is full. The trailing end-of-command byte is read and checked. The block then decodes a big-endian 32-bit length from the packet header and checks that length against the number of bytes it actually received.

The mailbox is reached through a one-cycle read strobe with a select line: status (0) or data (1). The read data is sampled in the same cycle as the strobe. A data read pops the mailbox. Received bytes leave through an address, data and write-enable port. The block ends the sequence with a one-cycle `done`. At that point it presents the byte count, the decoded length and a 3-bit result code. The states are as follows:
- S_IDLE waits for `start`, then goes to S_WAIT_HEAD.
- S_WAIT_HEAD polls status until the frame flag is set, then goes to S_GET_MODE.
- S_GET_MODE reads the mode byte, then goes to S_POLL_OUT.
- S_POLL_OUT waits for output-full. It goes to S_GET_BYTE for a payload byte, or to S_GET_TAIL when the frame flag is also set. When the buffer is full it goes to S_WAIT_TAIL.
- S_GET_BYTE stores one byte and returns to S_POLL_OUT.
- S_WAIT_TAIL polls for the frame flag, then goes to S_GET_TAIL.
- S_GET_TAIL checks the trailer, then goes to S_JUDGE.
- S_JUDGE checks the length field, then goes to S_REPORT.
- S_REPORT pulses `done` and returns to S_IDLE.

Any failed check or timeout jumps directly to S_REPORT.

Top module: `rsp_rx_seq`

## Requirements
- R1: After `start`, the block issues only status reads (`mb_sel`=0) until a status value with bit 2 (frame flag) set is seen. It issues no data read before that.
- R2: The first data byte must be 0x01. Any other value ends the sequence with result code 2 and `rx_count` 0, after exactly one data read.
- R3: A status value with bit 0 (output full) set and bit 2 clear leads to one data read. That byte is written to the buffer at the next address, starting from address 0.
- R4: A status value with bits 0 and 2 both set ends the payload phase. The byte then read is treated as the trailer, not stored, so a normal packet of n payload bytes costs n+2 data reads.
- R5: Once `rx_count` equals BUF_DEPTH, no further payload read occurs. The block polls status for bit 2 and then reads the trailer.
- R6: A trailer byte other than 0x03 gives result code 5.
- R7: When `tmo_limit` consecutive polls fail, the sequence ends with a timeout code. The code is 1 while waiting for the head flag, 3 while waiting for a payload byte, and 4 while waiting for the frame flag after a full buffer.
- R8: The decoded length is the 32-bit value in buffer bytes 2..5, with byte 2 most significant.
- R9: Fewer than 6 stored bytes gives code 6. A decoded length larger than `rx_count` gives code 7. Otherwise the code is 0 and `rsp_len` holds the decoded length.
- R10: `done` is high for exactly one cycle per sequence. `err` is high exactly when `done` is high and the code is nonzero. `rx_count` equals the number of stored bytes.
- R11: After reset, `done`, `err`, `mb_rd` and `buf_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin receiving one packet (taken in S_IDLE only) |
| tmo_limit | input | TMR_W | Consecutive failed polls before timeout |
| mb_rd | output | 1 | Mailbox read strobe |
| mb_sel | output | 1 | 0 = status port, 1 = data port |
| mb_rdata | input | 8 | Mailbox read data, valid while `mb_rd` is high |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | $clog2(BUF_DEPTH) | Buffer write address |
| buf_wdata | output | 8 | Buffer write data |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Error flag, valid with `done` |
| err_code | output | 3 | Result code (0 = good) |
| rx_count | output | $clog2(BUF_DEPTH+1) | Stored payload bytes |
| rsp_len | output | 32 | Decoded big-endian length |

## Verification
The mailbox model in the bench is fed randomly sized packets with random poll delays. About half of these packets carry a header length within the received count and the rest carry one beyond it, which separates the code 0 path from the code 7 path. Directed packets cover the following cases:
- a head flag that never rises, a wrong mode byte, and a stall in mid-payload, which separate the three timeout and framing outcomes;
- a payload exactly as long as the buffer, and one longer than the buffer, which separate the clean stop at capacity from the tail timeout;
- empty and short packets;
- a length equal to the count and one above it;
- a length with only its top byte set, which exposes byte-order faults.

Counting data reads separates a trailer consumed as the frame end from one wrongly stored as payload.

// File: rtl/rsp_rx_pkg.sv
package rsp_rx_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WAIT_HEAD,
        S_GET_MODE,
        S_POLL_OUT,
        S_GET_BYTE,
        S_WAIT_TAIL,
        S_GET_TAIL,
        S_JUDGE,
        S_REPORT
    } rx_state_e;

    typedef enum logic [2:0] {
        E_NONE     = 3'd0,
        E_TO_HEAD  = 3'd1,
        E_FRAME    = 3'd2,
        E_TO_BYTE  = 3'd3,
        E_TO_TAIL  = 3'd4,
        E_TAIL     = 3'd5,
        E_SHORT    = 3'd6,
        E_LENGTH   = 3'd7
    } rx_err_e;

    localparam logic [7:0] MODE_NORMAL = 8'h01;
    localparam logic [7:0] CODE_EOC    = 8'h03;
    localparam int         BIT_FULL    = 0;
    localparam int         BIT_FRAME   = 2;
    localparam int         HDR_FIRST   = 2;
    localparam int         HDR_LAST    = 5;
    localparam int         MIN_BYTES   = HDR_LAST + 1;

endpackage

// File: rtl/poll_timer.sv
module poll_timer #(
    parameter int TMR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             miss,
    input  logic [TMR_W-1:0] limit,
    output logic             expired
);
    logic [TMR_W-1:0] cnt_q;
    logic [TMR_W:0]   cnt_nxt;

    assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
    assign expired = miss && (cnt_nxt >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (miss)
            cnt_q <= cnt_nxt[TMR_W-1:0];
    end
endmodule

// File: rtl/hdr_len_capture.sv
module hdr_len_capture
    import rsp_rx_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [31:0]   len
);
    logic in_field;

    assign in_field = (int'(addr) >= HDR_FIRST) && (int'(addr) <= HDR_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            len <= '0;
        else if (clear)
            len <= '0;
        else if (we && in_field)
            len <= {len[23:0], wdata};
    end
endmodule

// File: rtl/rsp_rx_seq.sv
module rsp_rx_seq
    import rsp_rx_pkg::*;
#(
    parameter int BUF_DEPTH = 16,
    parameter int TMR_W     = 32,
    localparam int AW = $clog2(BUF_DEPTH),
    localparam int CW = $clog2(BUF_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TMR_W-1:0] tmo_limit,
    output logic             mb_rd,
    output logic             mb_sel,
    input  logic [7:0]       mb_rdata,
    output logic             buf_we,
    output logic [AW-1:0]    buf_addr,
    output logic [7:0]       buf_wdata,
    output logic             done,
    output logic             err,
    output logic [2:0]       err_code,
    output logic [CW-1:0]    rx_count,
    output logic [31:0]      rsp_len
);
    rx_state_e state_q, state_d;
    rx_err_e   code_q, fail_code;
    logic      fail;
    logic [CW-1:0] cnt_q;
    logic [31:0]   len_w;
    logic      miss, expired, full, st_full, st_frame, launch;

    assign full     = (cnt_q == CW'(BUF_DEPTH));
    assign st_full  = mb_rdata[BIT_FULL];
    assign st_frame = mb_rdata[BIT_FRAME];
    assign launch   = (state_q == S_IDLE) && start;

    poll_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!miss),
        .miss    (miss),
        .limit   (tmo_limit),
        .expired (expired)
    );

    hdr_len_capture #(.AW(AW)) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (launch),
        .we    (buf_we),
        .addr  (buf_addr),
        .wdata (buf_wdata),
        .len   (len_w)
    );

    // next state and failure decode
    always_comb begin
        state_d   = state_q;
        fail      = 1'b0;
        fail_code = E_NONE;
        unique case (state_q)
            S_IDLE:      if (start) state_d = S_WAIT_HEAD;
            S_WAIT_HEAD: begin
                if (st_frame)     state_d = S_GET_MODE;
                else if (expired) begin fail = 1'b1; fail_code = E_TO_HEAD; end
            end
            S_GET_MODE: begin
                if (mb_rdata == MODE_NORMAL) state_d = S_POLL_OUT;
                else begin fail = 1'b1; fail_code = E_FRAME; end
            end
            S_POLL_OUT: begin
                if (full)                      state_d = S_WAIT_TAIL;
                else if (st_full && st_frame)  state_d = S_GET_TAIL;
                else if (st_full)              state_d = S_GET_BYTE;
                else if (expired) begin fail = 1'b1; fail_code = E_TO_BYTE; end
            end
            S_GET_BYTE:  state_d = S_POLL_OUT;
            S_WAIT_TAIL: begin
                if (st_frame)     state_d = S_GET_TAIL;
                else if (expired) begin fail = 1'b1; fail_code = E_TO_TAIL; end
            end
            S_GET_TAIL: begin
                if (mb_rdata == CODE_EOC) state_d = S_JUDGE;
                else begin fail = 1'b1; fail_code = E_TAIL; end
            end
            S_JUDGE: begin
                state_d = S_REPORT;
                if (32'(cnt_q) < 32'(MIN_BYTES)) begin
                    fail = 1'b1; fail_code = E_SHORT;
                end else if (len_w > 32'(cnt_q)) begin
                    fail = 1'b1; fail_code = E_LENGTH;
                end
            end
            S_REPORT:    state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
        if (fail) state_d = S_REPORT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // byte count and result code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            code_q <= E_NONE;
        end else begin
            if (launch) begin
                cnt_q  <= '0;
                code_q <= E_NONE;
            end else begin
                if (buf_we) cnt_q <= cnt_q + 1'b1;
                if (fail)   code_q <= fail_code;
            end
        end
    end

    // outputs
    always_comb begin
        mb_rd  = 1'b0;
        mb_sel = 1'b0;
        buf_we = 1'b0;
        done   = 1'b0;
        miss   = 1'b0;
        unique case (state_q)
            S_WAIT_HEAD: begin mb_rd = 1'b1; miss = !st_frame; end
            S_GET_MODE:  begin mb_rd = 1'b1; mb_sel = 1'b1; end
            S_POLL_OUT:  begin mb_rd = !full; miss = !full && !st_full; end
            S_GET_BYTE:  begin mb_rd = 1'b1; mb_sel = 1'b1; buf_we = 1'b1; end
            S_WAIT_TAIL: begin mb_rd = 1'b1; miss = !st_frame; end
            S_GET_TAIL:  begin mb_rd = 1'b1; mb_sel = 1'b1; end
            S_REPORT:    done = 1'b1;
            default:     ;
        endcase
    end

    assign buf_addr  = cnt_q[AW-1:0];
    assign buf_wdata = mb_rdata;
    assign err       = done && (code_q != E_NONE);
    assign err_code  = code_q;
    assign rx_count  = cnt_q;
    assign rsp_len   = len_w;
endmodule

// File: rtl/rsp_rx_chk.sv
module rsp_rx_chk #(
    parameter int BUF_DEPTH = 16,
    localparam int CW = $clog2(BUF_DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          err,
    input logic          buf_we,
    input logic          mb_rd,
    input logic          mb_sel,
    input logic [CW-1:0] rx_count,
    input logic [31:0]   rsp_len
);
    // R10: single-cycle completion pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: error only reported alongside completion
    a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R5: stored count never passes capacity
    a_r5_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(BUF_DEPTH));

    // R3: every buffer write comes from a data-port read
    a_r3_write_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (mb_rd && mb_sel));

    // R9: a clean result has a full header and a length within the count
    a_r9_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (rsp_len <= 32'(rx_count) && rx_count >= CW'(6)));

    // R10: no mailbox traffic in the completion cycle
    a_r10_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mb_rd);
endmodule

bind rsp_rx_seq rsp_rx_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .err      (err),
    .buf_we   (buf_we),
    .mb_rd    (mb_rd),
    .mb_sel   (mb_sel),
    .rx_count (rx_count),
    .rsp_len  (rsp_len)
);

// File: tb/rsp_rx_seq_tb.sv
module rsp_rx_seq_tb;
    localparam int DEPTH = 16;
    localparam int TW    = 32;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int LIMIT = 40;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [TW-1:0] tmo_limit = TW'(LIMIT);
    logic mb_rd, mb_sel, buf_we, done, err;
    logic [7:0] mb_rdata, buf_wdata;
    logic [AW-1:0] buf_addr;
    logic [2:0] err_code;
    logic [CW-1:0] rx_count;
    logic [31:0] rsp_len;

    always #5 clk = ~clk;

    rsp_rx_seq #(.BUF_DEPTH(DEPTH), .TMR_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tmo_limit(tmo_limit),
        .mb_rd(mb_rd), .mb_sel(mb_sel), .mb_rdata(mb_rdata),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .done(done), .err(err), .err_code(err_code),
        .rx_count(rx_count), .rsp_len(rsp_len)
    );

    // mailbox model configuration
    logic       c_never = 1'b0;
    logic [7:0] c_mode = 8'h01, c_eoc = 8'h03;
    int         c_n = 0, c_stall = -1, c_dly = 0;
    logic [7:0] pay [0:31];
    logic       m_load = 1'b0;

    int m_phase = 2, m_idx = 0, m_dly = 0;
    int n_drd = 0;
    logic [7:0] cap [0:DEPTH-1];

    always_comb begin
        mb_rdata = 8'h00;
        if (m_phase == 0) begin
            if (mb_sel) mb_rdata = c_mode;
            else if (!c_never && m_dly == 0) mb_rdata = 8'h04;
        end else if (m_phase == 1) begin
            if (m_idx < c_n) begin
                if (mb_sel) mb_rdata = pay[m_idx];
                else if (m_dly == 0 && m_idx != c_stall) mb_rdata = 8'h01;
            end else begin
                if (mb_sel) mb_rdata = c_eoc;
                else if (m_dly == 0) mb_rdata = 8'h05;
            end
        end
    end

    always @(posedge clk) begin
        if (m_load) begin
            m_phase <= 0; m_idx <= 0; m_dly <= c_dly; n_drd <= 0;
        end else begin
            if (m_dly > 0) m_dly <= m_dly - 1;
            if (mb_rd && mb_sel) begin
                n_drd <= n_drd + 1;
                if (m_phase == 0) begin
                    m_phase <= 1; m_dly <= c_dly;
                end else if (m_phase == 1) begin
                    if (m_idx < c_n) begin m_idx <= m_idx + 1; m_dly <= c_dly; end
                    else m_phase <= 2;
                end
            end
            if (buf_we) cap[buf_addr] <= buf_wdata;
        end
    end

    int n_chk = 0, n_bad = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_code(input int len);
        if (c_never)                                   return 1;
        if (c_mode != 8'h01)                           return 2;
        if (c_stall >= 0 && c_stall < c_n && c_stall < DEPTH) return 3;
        if (c_n > DEPTH)                               return 4;
        if (c_eoc != 8'h03)                            return 5;
        if (c_n < 6)                                   return 6;
        if (len > c_n)                                 return 7;
        return 0;
    endfunction

    function automatic int exp_count();
        if (c_never || c_mode != 8'h01) return 0;
        if (c_stall >= 0 && c_stall < c_n && c_stall < DEPTH) return c_stall;
        return (c_n > DEPTH) ? DEPTH : c_n;
    endfunction

    function automatic int exp_drd();
        if (c_never) return 0;
        if (c_mode != 8'h01) return 1;
        if (c_stall >= 0 && c_stall < c_n && c_stall < DEPTH) return 1 + c_stall;
        if (c_n > DEPTH) return 1 + DEPTH;
        return c_n + 2;
    endfunction

    task automatic run(input bit never, input logic [7:0] mode, input int n,
                       input int stall, input logic [7:0] eoc, input logic [31:0] len,
                       input int dly);
        int ec, ecnt, edr, waited;
        bit seen_sel_data;
        bit buf_ok;
        c_never = never; c_mode = mode; c_n = n; c_stall = stall;
        c_eoc = eoc; c_dly = dly;
        for (int i = 0; i < 32; i++) pay[i] = 8'($urandom);
        pay[2] = len[31:24]; pay[3] = len[23:16]; pay[4] = len[15:8]; pay[5] = len[7:0];
        @(negedge clk);
        m_load = 1'b1; start = 1'b1;
        @(negedge clk);
        m_load = 1'b0; start = 1'b0;
        waited = 0;
        seen_sel_data = 1'b0;
        while (!done && waited < 3000) begin
            if (never && mb_rd && mb_sel) seen_sel_data = 1'b1;
            @(negedge clk);
            waited++;
        end
        ec   = exp_code(int'(len));
        ecnt = exp_count();
        edr  = exp_drd();
        check(done, "R10 done seen", done, 1);
        check(err_code == 3'(ec), "R2/R6/R7/R9 code", err_code, ec);
        check(err == (ec != 0), "R10 err flag", err, ec != 0);
        check(int'(rx_count) == ecnt, "R10 rx_count", rx_count, ecnt);
        check(n_drd == edr, "R4/R5 data reads", n_drd, edr);
        if (never) check(!seen_sel_data, "R1 no data read before head", seen_sel_data, 0);
        if (ec == 0) check(rsp_len == len, "R8 length", rsp_len, len);
        buf_ok = 1'b1;
        for (int i = 0; i < ecnt; i++) if (cap[i] !== pay[i]) buf_ok = 1'b0;
        check(buf_ok, "R3 buffer contents", buf_ok, 1);
        @(negedge clk);
        check(!done, "R10 done one cycle", done, 0);
    endtask

    initial begin
        #1500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        check(!done && !err && !mb_rd && !buf_we, "R11 reset state",
              {done, err, mb_rd, buf_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mb_rd && !done, "R11 idle after reset", mb_rd, 0);

        // directed corner cases
        run(1'b1, 8'h01, 8, -1, 8'h03, 32'd6, 0);            // R7 head timeout
        run(1'b0, 8'h02, 8, -1, 8'h03, 32'd6, 1);            // R2 bad mode
        run(1'b0, 8'h01, 10, 4, 8'h03, 32'd6, 0);            // R7 payload stall
        run(1'b0, 8'h01, DEPTH, -1, 8'h03, 32'(DEPTH), 2);   // R5 exact capacity
        run(1'b0, 8'h01, DEPTH + 3, -1, 8'h03, 32'd6, 0);    // R7 tail timeout
        run(1'b0, 8'h01, 3, -1, 8'h03, 32'd3, 1);            // R9 short
        run(1'b0, 8'h01, 0, -1, 8'h03, 32'd0, 0);            // R9 empty
        run(1'b0, 8'h01, 9, -1, 8'h03, 32'd9, 0);            // R9 len == count
        run(1'b0, 8'h01, 9, -1, 8'h03, 32'd10, 0);           // R9 len = count+1
        run(1'b0, 8'h01, 9, -1, 8'h07, 32'd9, 1);            // R6 bad trailer
        run(1'b0, 8'h01, 12, -1, 8'h03, 32'h0100_0000, 0);   // R8 byte order

        // constrained random packets
        for (int k = 0; k < 40; k++) begin
            int n;
            logic [31:0] len;
            n = 6 + int'($urandom_range(DEPTH - 6));
            if ($urandom_range(1) == 0) len = 32'($urandom_range(n));
            else len = 32'(n) + 32'($urandom_range(300, 1));
            run(1'b0, ($urandom_range(9) == 0) ? 8'h11 : 8'h01, n, -1,
                ($urandom_range(9) == 0) ? 8'h30 : 8'h03, len,
                int'($urandom_range(3)));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule